// File: doc/BRIEF.md
# Virtual Address Region Decoder with Fault Capture

This block sits between a processor's address generation and its memory path. Every 32-bit virtual access arrives with its kind (load, store or instruction fetch) and the privilege mode it runs in. The block sorts the address into one of three regions. A direct region maps one-to-one to physical memory. A mapped region is resolved by a translation lookaside buffer outside this block. A denied region is one the current mode may not touch. The decode is purely combinational. It returns either a physical address or a fault together with its cause code.

When a faulting access is marked valid, three fault-capture registers are loaded on that clock edge: a miss-info register carrying a data/fetch flag, a page-table pointer register and a bad-address register. A handler reads them later. The lookup buffer, its contents and its replacement policy are outside this block. The block only consumes the result of one lookup: a hit flag, a physical frame address, the virtual base of the matching entry and three permission bits. When the parameter `MMU_PRESENT` is 0, the block passes every address through unchanged and never faults.

Top module: `mmu_region_xlate`

## Requirements
- R1: In supervisor mode, an address at or above 0xC000_0000 gives `paddr_o` equal to the address and no fault, whatever the lookup result.
- R2: A supervisor address in 0x8000_0000..0xBFFF_FFFF, and an address below 0x8000_0000 in either mode, uses the lookup. On a hit with the needed permission, `paddr_o` = frame + (vaddr − vbase) and there is no fault.
- R3: In user mode, an address at or above 0x8000_0000 faults with cause 5. The bad-address register takes the address, and the miss-info and page-table pointer registers keep their values.
- R4: Access kind 0 is a load and needs permission bit 0. Kind 1 is a store and needs bit 1. Kinds 2 and 3 are fetches and need bit 2. A hit without the needed bit faults with cause 2, 3 or 4 for load, store or fetch.
- R5: A lookup miss in a mapped region faults with cause 1, whatever the permission bits are.
- R6: On a mapped-region fault, bit 2 of the miss-info register is cleared for a fetch and set for a load or store. Its other bits stay 0.
- R7: On a mapped-region fault, bits 31:22 of the page-table pointer are kept. Bits 21:2 take vaddr[31:12] (the address shifted right by 10 bits), and bits 1:0 become 0.
- R8: On any valid fault, the bad-address register takes the full faulting address.
- R9: With `acc_valid_i` low, `fault_o` is 0, `cause_o` is 0 and no register changes. With no fault, `cause_o` is 0 and no register changes.
- R10: With `MMU_PRESENT` = 0, `paddr_o` equals the address and no access faults.
- R11: After reset, the miss-info and bad-address registers are 0 and the page-table pointer holds `PTE_RST` (default 0xA5C0_0003).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access present this cycle |
| vaddr_i | input | 32 | Virtual address |
| acc_kind_i | input | 2 | 0 load, 1 store, 2/3 fetch |
| super_i | input | 1 | Supervisor mode |
| tlb_hit_i | input | 1 | Lookup found an entry |
| tlb_frame_i | input | 32 | Physical base of the matching entry |
| tlb_vbase_i | input | 32 | Virtual base of the matching entry |
| tlb_perm_i | input | 3 | Permissions {fetch, store, load} |
| paddr_o | output | 32 | Physical address |
| fault_o | output | 1 | Access faults |
| cause_o | output | 5 | Fault cause, 0 when none |
| missinfo_o | output | 32 | Miss-info register |
| ptaddr_o | output | 32 | Page-table pointer register |
| badaddr_o | output | 32 | Bad-address register |

## Verification
The assertions assume that the inputs are stable between clock edges. They also assume that lookup fields are meaningful only in mapped regions. Frame and virtual base are taken as any 32-bit values, with the sum wrapping modulo 2^32. The stimulus changes inputs only on falling edges and drives them from a sweep over modes, region-boundary addresses, access kinds, hit and all permission patterns. This covers every input combination the properties condition on, including accesses held invalid.

// File: rtl/mmu_xl_pkg.sv
package mmu_xl_pkg;
  typedef enum logic [4:0] {
    CS_NONE    = 5'd0,
    CS_MISS    = 5'd1,
    CS_PERM_RD = 5'd2,
    CS_PERM_WR = 5'd3,
    CS_PERM_EX = 5'd4,
    CS_SUPER   = 5'd5
  } cause_e;

  typedef enum logic [1:0] {
    RG_DIRECT = 2'd0,
    RG_MAPPED = 2'd1,
    RG_DENIED = 2'd2
  } region_e;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
endpackage

// File: rtl/mmu_region_dec.sv
module mmu_region_dec
  import mmu_xl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter bit MMU_PRESENT = 1'b1,
  parameter logic [ADDR_W-1:0] USER_LIMIT  = 'h8000_0000,
  parameter logic [ADDR_W-1:0] DIRECT_BASE = 'hC000_0000
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic              super_i,
  output region_e           region_o
);
  generate
    if (!MMU_PRESENT) begin : g_flat
      logic unused_in;
      assign unused_in = ^{vaddr_i, super_i};
      assign region_o  = RG_DIRECT;
    end else begin : g_seg
      always_comb begin
        if (super_i) begin
          region_o = (vaddr_i >= DIRECT_BASE) ? RG_DIRECT : RG_MAPPED;
        end else begin
          region_o = (vaddr_i >= USER_LIMIT) ? RG_DENIED : RG_MAPPED;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mmu_perm_chk.sv
module mmu_perm_chk
  import mmu_xl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              hit_i,
  input  logic [2:0]        perm_i,
  input  logic [ADDR_W-1:0] frame_i,
  input  logic [ADDR_W-1:0] vbase_i,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              ok_o,
  output cause_e            cause_o
);
  logic granted;

  always_comb begin
    paddr_o = frame_i + (vaddr_i - vbase_i);
    unique case (acc_kind_i)
      ACC_LOAD:  granted = perm_i[0];
      ACC_STORE: granted = perm_i[1];
      default:   granted = perm_i[2];
    endcase
    ok_o = hit_i && granted;
    if (!hit_i) begin
      cause_o = CS_MISS;
    end else if (!granted) begin
      unique case (acc_kind_i)
        ACC_LOAD:  cause_o = CS_PERM_RD;
        ACC_STORE: cause_o = CS_PERM_WR;
        default:   cause_o = CS_PERM_EX;
      endcase
    end else begin
      cause_o = CS_NONE;
    end
  end
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned VPN_LSB   = 2,
  parameter int unsigned DFLAG_BIT = 2,
  parameter logic [ADDR_W-1:0] PTE_RST = 'hA5C0_0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              mapped_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic [ADDR_W-1:0] missinfo_o,
  output logic [ADDR_W-1:0] ptaddr_o,
  output logic [ADDR_W-1:0] badaddr_o
);
  localparam int unsigned VPN_W      = ADDR_W - PAGE_BITS;
  localparam int unsigned SHIFT      = PAGE_BITS - VPN_LSB;
  localparam int unsigned BASE_LSB   = VPN_LSB + VPN_W;
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] VPN_MASK  = ((ONE << VPN_W) - ONE) << VPN_LSB;
  localparam logic [ADDR_W-1:0] BASE_MASK = ~((ONE << BASE_LSB) - ONE);

  logic [ADDR_W-1:0] pt_next, mi_next;

  always_comb begin
    pt_next = (ptaddr_o & BASE_MASK) | ((vaddr_i >> SHIFT) & VPN_MASK);
    mi_next = missinfo_o;
    mi_next[DFLAG_BIT] = !fetch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      missinfo_o <= '0;
      ptaddr_o   <= PTE_RST;
      badaddr_o  <= '0;
    end else if (upd_i) begin
      badaddr_o <= vaddr_i;
      if (mapped_i) begin
        missinfo_o <= mi_next;
        ptaddr_o   <= pt_next;
      end
    end
  end

  p_base_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && mapped_i) |=> ((ptaddr_o & BASE_MASK) == $past(ptaddr_o & BASE_MASK)));

  p_regs_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(ptaddr_o) && $stable(missinfo_o) && $stable(badaddr_o)));

  p_denied_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !mapped_i) |=> ($stable(ptaddr_o) && $stable(missinfo_o)));

  p_dflag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && mapped_i) |=> (missinfo_o[DFLAG_BIT] == !$past(fetch_i)));
endmodule

// File: rtl/mmu_region_xlate.sv
module mmu_region_xlate
  import mmu_xl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter bit          MMU_PRESENT = 1'b1,
  parameter logic [ADDR_W-1:0] USER_LIMIT  = 'h8000_0000,
  parameter logic [ADDR_W-1:0] DIRECT_BASE = 'hC000_0000,
  parameter int unsigned VPN_LSB   = 2,
  parameter int unsigned DFLAG_BIT = 2,
  parameter logic [ADDR_W-1:0] PTE_RST = 'hA5C0_0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              super_i,
  input  logic              tlb_hit_i,
  input  logic [ADDR_W-1:0] tlb_frame_i,
  input  logic [ADDR_W-1:0] tlb_vbase_i,
  input  logic [2:0]        tlb_perm_i,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              fault_o,
  output logic [4:0]        cause_o,
  output logic [ADDR_W-1:0] missinfo_o,
  output logic [ADDR_W-1:0] ptaddr_o,
  output logic [ADDR_W-1:0] badaddr_o
);
  region_e           region;
  logic [ADDR_W-1:0] xl_paddr;
  logic              xl_ok;
  cause_e            xl_cause;
  logic              flt;
  cause_e            cause;

  mmu_region_dec #(
    .ADDR_W(ADDR_W), .MMU_PRESENT(MMU_PRESENT),
    .USER_LIMIT(USER_LIMIT), .DIRECT_BASE(DIRECT_BASE)
  ) u_dec (
    .vaddr_i(vaddr_i), .super_i(super_i), .region_o(region)
  );

  mmu_perm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .vaddr_i(vaddr_i), .acc_kind_i(acc_kind_i), .hit_i(tlb_hit_i),
    .perm_i(tlb_perm_i), .frame_i(tlb_frame_i), .vbase_i(tlb_vbase_i),
    .paddr_o(xl_paddr), .ok_o(xl_ok), .cause_o(xl_cause)
  );

  always_comb begin
    unique case (region)
      RG_MAPPED: begin
        paddr_o = xl_paddr;
        flt     = !xl_ok;
        cause   = xl_cause;
      end
      RG_DENIED: begin
        paddr_o = vaddr_i;
        flt     = 1'b1;
        cause   = CS_SUPER;
      end
      default: begin
        paddr_o = vaddr_i;
        flt     = 1'b0;
        cause   = CS_NONE;
      end
    endcase
  end

  assign fault_o = acc_valid_i && flt;
  assign cause_o = fault_o ? cause : CS_NONE;

  mmu_fault_regs #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .VPN_LSB(VPN_LSB),
    .DFLAG_BIT(DFLAG_BIT), .PTE_RST(PTE_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(fault_o),
    .mapped_i(region == RG_MAPPED), .fetch_i(acc_kind_i[1]),
    .vaddr_i(vaddr_i), .missinfo_o(missinfo_o), .ptaddr_o(ptaddr_o),
    .badaddr_o(badaddr_o)
  );

  generate
    if (MMU_PRESENT) begin : g_seg_chk
      p_direct_ident_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && super_i && vaddr_i >= DIRECT_BASE) |-> (paddr_o == vaddr_i && !fault_o));
      p_user_denied_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && !super_i && vaddr_i >= USER_LIMIT) |-> (fault_o && cause_o == CS_SUPER));
      p_miss_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && !tlb_hit_i && vaddr_i < USER_LIMIT) |-> (fault_o && cause_o == CS_MISS));
    end else begin : g_flat_chk
      p_no_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o && paddr_o == vaddr_i);
    end
  endgenerate

  p_badaddr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (badaddr_o == $past(vaddr_i)));

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (cause_o == CS_NONE));

  p_cause_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (cause_o != CS_NONE));
endmodule

// File: tb/tb_mmu_region_xlate.sv
module tb_mmu_region_xlate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PTE_INIT = 32'hA5C0_0003;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, sup = 1'b0, hit = 1'b0;
  logic [31:0] va = '0, frame = '0, vbase = '0;
  logic [1:0]  kind = '0;
  logic [2:0]  perm = '0;
  logic [31:0] paddr, mi, pt, bad, paddr_n, mi_n, pt_n, bad_n;
  logic        fault, fault_n;
  logic [4:0]  cause, cause_n;

  int checks = 0, errors = 0;
  logic [31:0] m_mi, m_pt, m_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_region_xlate dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .vaddr_i(va),
    .acc_kind_i(kind), .super_i(sup), .tlb_hit_i(hit), .tlb_frame_i(frame),
    .tlb_vbase_i(vbase), .tlb_perm_i(perm), .paddr_o(paddr), .fault_o(fault),
    .cause_o(cause), .missinfo_o(mi), .ptaddr_o(pt), .badaddr_o(bad));

  mmu_region_xlate #(.MMU_PRESENT(1'b0)) dut_flat (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .vaddr_i(va),
    .acc_kind_i(kind), .super_i(sup), .tlb_hit_i(hit), .tlb_frame_i(frame),
    .tlb_vbase_i(vbase), .tlb_perm_i(perm), .paddr_o(paddr_n), .fault_o(fault_n),
    .cause_o(cause_n), .missinfo_o(mi_n), .ptaddr_o(pt_n), .badaddr_o(bad_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One access: check combinational outputs, then registers after the edge.
  task automatic access(input logic v, input logic s, input logic [31:0] a,
                        input logic [1:0] k, input logic h, input logic [2:0] p,
                        input logic [31:0] fr, input logic [31:0] vb);
    logic ef; logic [4:0] ec; logic [31:0] ep; logic mapped; logic grant;
    @(negedge clk);
    valid = v; sup = s; va = a; kind = k; hit = h; perm = p; frame = fr; vbase = vb;
    grant  = (k == 2'd0) ? p[0] : (k == 2'd1) ? p[1] : p[2];
    mapped = 1'b0; ef = 1'b0; ec = 5'd0; ep = a;
    if (s && a >= 32'hC000_0000) begin
      ef = 1'b0;
    end else if (!s && a >= 32'h8000_0000) begin
      ef = 1'b1; ec = 5'd5;
    end else begin
      mapped = 1'b1;
      ep = fr + a - vb;
      if (!h) begin ef = 1'b1; ec = 5'd1; end
      else if (!grant) begin ef = 1'b1; ec = (k == 2'd0) ? 5'd2 : (k == 2'd1) ? 5'd3 : 5'd4; end
    end
    if (!v) begin ef = 1'b0; ec = 5'd0; end
    #1;
    chk("R3/R5/R9 fault", {31'b0, fault}, {31'b0, ef});
    chk("R4/R5/R9 cause", {27'b0, cause}, {27'b0, ec});
    if (!ef && v) chk("R1/R2 paddr", paddr, ep);
    chk("R10 flat paddr", paddr_n, a);
    chk("R10 flat fault", {31'b0, fault_n}, 32'd0);
    if (ef) begin
      m_bad = a;
      if (mapped) begin
        m_mi[2] = !k[1];
        m_pt = (m_pt & 32'hFFC0_0000) | {10'b0, a[31:12], 2'b00};
      end
    end
    @(posedge clk); #1;
    chk("R8/R9 badaddr", bad, m_bad);
    chk("R6/R9 missinfo", mi, m_mi);
    chk("R7/R3 ptaddr", pt, m_pt);
  endtask

  logic [31:0] addrs [6] = '{32'h0000_1234, 32'h7FFF_FFFC, 32'h8000_0ABC,
                             32'hBFFF_FFFF, 32'hC000_0000, 32'hFFFF_F010};

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_mi = '0; m_pt = PTE_INIT; m_bad = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 missinfo", mi, 32'd0);
    chk("R11 ptaddr", pt, PTE_INIT);
    chk("R11 badaddr", bad, 32'd0);
    chk("R11 flat ptaddr", pt_n, PTE_INIT);

    // R9: invalid faulting accesses leave registers alone
    access(1'b0, 1'b0, 32'h9000_0000, 2'd0, 1'b0, 3'd0, 32'h0, 32'h0);
    access(1'b0, 1'b1, 32'h0000_5000, 2'd2, 1'b0, 3'd0, 32'h0, 32'h0);

    for (int s = 0; s < 2; s++)
      for (int ai = 0; ai < 6; ai++)
        for (int k = 0; k < 4; k++)
          for (int h = 0; h < 2; h++)
            for (int p = 0; p < 8; p++) begin
              logic [31:0] a, fr, vb;
              a  = addrs[ai] ^ (32'(p) << 12);
              if (ai == 5) a = addrs[ai];
              fr = 32'h0ABC_D000 + (32'(k * 8 + p) << 12);
              vb = (p == 5) ? ({a[31:12], 12'h000} - 32'h1000) : {a[31:12], 12'h000};
              access(1'b1, s[0], a, k[1:0], h[0], p[2:0], fr, vb);
            end

    // R9: one more invalid access after faults have loaded the registers
    access(1'b0, 1'b0, 32'hFFFF_FFFF, 2'd1, 1'b0, 3'd0, 32'h0, 32'h0);
    chk("R10 flat regs untouched", bad_n, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule